// File: doc/BRIEF.md
# Set-Choice Predictor for a Compressed DRAM Cache

A compressed DRAM cache can place a line in either of two neighbouring sets: the set given by conventional low-bit indexing, or the set given by a bandwidth-aware index that pairs even and odd lines into one slot. A lookup that probes the right set first saves a tag comparison. This block keeps a small direct-mapped table of one-bit hints, one per page-number slice. A read request gets the scheme that last hit for its page. A write request does not use the table. Its prediction follows the compressibility of the line being written.

The prediction is combinational and appears in the same cycle as the request. Once a read lookup resolves, the cache controller returns the outcome on the update port. A hit in either set overwrites the hint with the scheme that hit. A miss in both sets leaves the hint unchanged. The asynchronous reset sets every hint to the conventional scheme.

Top module: `cip_table`

## Requirements
- R1: While reset is asserted and directly after it is released, every entry predicts the conventional scheme. The output encoding is 0 for conventional and 1 for bandwidth-aware.
- R2: A read request (is_write low) returns the entry chosen by address bits [19:12] only. Bits [11:0] never change the result.
- R3: An update with upd_valid and upd_hit high writes upd_hit_bw into the entry at upd_addr[19:12]. Reads see the new value from the next cycle on.
- R4: An update with upd_hit low leaves every entry unchanged.
- R5: A write request predicts bandwidth-aware when req_compressible is 1 and conventional when it is 0, whatever the table holds. A write request does not change the table.
- R6: When an update and a read request address the same entry in the same cycle, the read returns the value the entry held before the update.
- R7: An update changes at most the one entry it addresses. Address bits above bit 19 are ignored, so addresses that differ only there share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_is_write | input | 1 | Request is a write (1) or a read (0) |
| req_addr | input | 32 | Request byte address |
| req_compressible | input | 1 | Line to be written is compressible |
| pred_bw | output | 1 | Predicted scheme: 1 bandwidth-aware, 0 conventional |
| upd_valid | input | 1 | A resolved read outcome is presented |
| upd_addr | input | 32 | Byte address of the resolved read |
| upd_hit | input | 1 | Lookup hit in one of the two candidate sets |
| upd_hit_bw | input | 1 | Scheme whose set hit: 1 bandwidth-aware, 0 conventional |

## Verification
The bench aims first at the same-cycle collision. A design that bypasses the new value to the reader would return the update value one cycle early. Misses are mixed with hits, so a design that writes on every valid update would corrupt hints. Addresses that differ only in line-offset bits or only in bits above the index check the slice boundaries; a slice taken one bit off would split one page across entries or merge different pages. Write requests are issued against entries that hold the opposite value, so a design that consulted the table on writes would give the wrong answer.

// File: rtl/cip_table.sv
module cip_table #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_is_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_compressible,
  output logic              pred_bw,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_hit,
  input  logic              upd_hit_bw
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_HI  = PAGE_LSB + IDX_W;

  logic [ENTRIES-1:0] tbl;
  logic [IDX_W-1:0]   req_idx, upd_idx;
  logic               upd_we;

  assign req_idx = req_addr[PAGE_LSB +: IDX_W];
  assign upd_idx = upd_addr[PAGE_LSB +: IDX_W];
  assign upd_we  = upd_valid && upd_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      tbl <= '0;
    else if (upd_we) tbl[upd_idx] <= upd_hit_bw;

  assign pred_bw = req_is_write ? req_compressible : tbl[req_idx];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[PAGE_LSB-1:0], req_addr[ADDR_W-1:IDX_HI],
                              upd_addr[PAGE_LSB-1:0], upd_addr[ADDR_W-1:IDX_HI]};

  a_r3_hit_writes: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |=> tbl[$past(upd_idx)] == $past(upd_hit_bw));

  a_r4_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_hit) |=> $stable(tbl));

  a_r5_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_is_write && !upd_valid) |=> $stable(tbl));

  a_r7_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> $countones(tbl ^ $past(tbl)) <= 1);
endmodule

// File: tb/sim_cip_table.sv
`timescale 1ns/1ps
module sim_cip_table;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_is_write = 0;
  logic [31:0] req_addr = '0;
  logic        req_compressible = 0;
  logic        pred_bw;
  logic        upd_valid = 0;
  logic [31:0] upd_addr = '0;
  logic        upd_hit = 0;
  logic        upd_hit_bw = 0;

  int checks = 0;
  int errors = 0;
  bit model [256];

  always #2.5 clk = ~clk;

  cip_table u0 (
    .clk(clk), .rst_n(rst_n), .req_is_write(req_is_write), .req_addr(req_addr),
    .req_compressible(req_compressible), .pred_bw(pred_bw), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_hit(upd_hit), .upd_hit_bw(upd_hit_bw)
  );

  task automatic check(input string tag, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pred_bw=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit w, input logic [31:0] ra, input bit rc,
                      input bit uv, input logic [31:0] ua, input bit uh, input bit ub);
    bit exp;
    @(negedge clk);
    req_is_write = w; req_addr = ra; req_compressible = rc;
    upd_valid = uv; upd_addr = ua; upd_hit = uh; upd_hit_bw = ub;
    #1;
    exp = w ? rc : model[ra[19:12]];
    check(tag, pred_bw, exp);
    @(posedge clk);
    if (uv && uh && rst_n) model[ua[19:12]] = ub;
  endtask

  task automatic rd(input string tag, input logic [31:0] ra);
    step(tag, 0, ra, 0, 0, 0, 0, 0);
  endtask

  task automatic upd(input logic [31:0] ua, input bit uh, input bit ub);
    step("R3 update cycle", 0, ua, 0, 1, ua, uh, ub);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    rd("R1 during reset", 32'h0000_5000);
    rd("R1 during reset", 32'h000F_F000);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 256; i++) rd("R1 after reset", {12'h0, i[7:0], 12'h0});

    upd(32'h0000_5040, 1, 1);
    rd("R3 new value visible", 32'h0000_5000);
    rd("R2 offset bits ignored", 32'h0000_5FFF);
    rd("R2 neighbour untouched", 32'h0000_6000);
    rd("R7 high bits alias", 32'hABC0_5123);
    upd(32'h0000_5000, 0, 0);
    rd("R4 miss keeps entry", 32'h0000_5000);
    step("R6 collision old value", 0, 32'h0000_5800, 0, 1, 32'h0000_5000, 1, 0);
    rd("R6 update lands next cycle", 32'h0000_5000);
    step("R6 collision old value", 0, 32'h0000_5000, 0, 1, 32'h0000_5000, 1, 1);
    step("R5 write compressible", 1, 32'h0000_7000, 1, 0, 0, 0, 0);
    step("R5 write incompressible", 1, 32'h0000_5000, 0, 0, 0, 0, 0);
    rd("R5 write leaves table", 32'h0000_5000);
    rd("R5 write leaves table", 32'h0000_7000);
    upd(32'hFFF0_0000, 1, 1);
    rd("R7 high bits alias", 32'h0000_0000);
    rd("R7 other entry untouched", 32'h0000_1000);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, ua;
      ra = {$urandom_range(3,0) == 0 ? $urandom() : 32'h0, 12'h0} | {12'h0, 4'h0, 4'($urandom_range(15,0)), 12'($urandom())};
      ua = {$urandom(), 12'h0} | {12'h0, 4'h0, 4'($urandom_range(15,0)), 12'($urandom())};
      ra[31:20] = 12'($urandom());
      step("R2 R3 R4 R5 R6 random", 1'($urandom()), ra, 1'($urandom()),
           1'($urandom()), ua, 1'($urandom()), 1'($urandom()));
    end

    @(negedge clk); rst_n = 0;
    foreach (model[i]) model[i] = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 256; i++) rd("R1 after second reset", {12'h5A5, i[7:0], 12'h0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule